// File: doc/BRIEF.md
# Two-Wire Block Configuration Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It gives a bus host write and read access to a bank of six 8-bit configuration registers. The bank drives the rest of the chip through a flat parallel output. Both bus lines are sampled in the system clock domain, synchronised and deglitched. The slave detects START and STOP conditions and answers only its own 7-bit device address, 0x69. It pulls SDA low through an open-drain enable, `sda_oe`, for acknowledges and for read data. It never stretches the clock. Standard-mode rates of 100 kbit/s and below are the intended use. Bytes are eight bits, sent MSB first.

A write always uses block framing. After the address byte 0xD2, the host sends two bytes that the slave acknowledges and throws away: a command byte and a length byte. Data bytes after those fill the registers from index 0 upward. A read, with address byte 0xD3, first returns a length byte and then the register contents in ascending order. There is no random access: every transfer begins at register 0. The host may end either transfer with STOP after any whole byte.

Top module: `twi_block_regs`

## Requirements
- R1: During and after reset, `regs_o` holds the parameter `DEFAULTS`. Register k sits at bits [8k+7:8k], and `sda_oe` is low.
- R2: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). To acknowledge, it holds SDA low for the whole ninth SCL pulse of that byte.
- R3: For any other address byte, the slave gives no acknowledge. It keeps `sda_oe` low and changes no register until the next START or STOP.
- R4: In a write, the first two bytes after the address are acknowledged and discarded. They never reach a register.
- R5: In a write, the third and later bytes are stored into register 0, 1, 2, ... in turn. Each one is acknowledged.
- R6: A STOP after any whole byte ends the write. Registers already written keep their new values, and the others keep their previous values.
- R7: In a write, data bytes beyond register 5 are acknowledged but stored nowhere.
- R8: A read first returns the byte 0x06 (the register count), then registers 0 through 5 in order, MSB first. Bytes requested after register 5 read as 0xFF, because SDA is released.
- R9: If the host answers a read byte with NACK (SDA high in the ninth pulse), the slave stops transmitting and keeps SDA released until the next START or STOP.
- R10: `sda_oe` changes only while SCL is low. A repeated START in the middle of a transfer restarts address matching, and the new transfer again begins at register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | 48 | Register bank, register k in bits [8k+7:8k] |

## Verification
The bench targets the byte-position rules. If the two discarded bytes were miscounted, the write data would land one or two registers off, and the every-clock comparison with the reference bank would catch it. A write of eight data bytes checks that the overflow bytes neither wrap into register 0 nor get refused. A wrong address followed by more bytes checks that the slave stays silent. A read after a repeated START checks that the byte index restarts. A NACK on the first read byte checks that the slave releases SDA rather than driving garbage over the following clocks.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/twi_deglitch.sv
module twi_deglitch #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(STABLE + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic          q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      cnt  <= '0;
      q    <= 1'b1;
    end else begin
      sync <= {sync[0], line_i};
      if (sync[1] == q) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE - 1)) begin
        q   <= sync[1];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign line_o = q;
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
  parameter int NREG = 6,
  parameter int DW   = 8,
  parameter int IW   = 5,
  parameter logic [NREG*DW-1:0] DEFAULTS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r <= DEFAULTS[g*DW +: DW];
      else if (wr_en && wr_idx == IW'(g))
        r <= wr_data;
    end
    assign regs_o[g*DW +: DW] = r;
  end

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i)) rd_data = regs_o[i*DW +: DW];
  end
endmodule

// File: rtl/twi_block_regs.sv
module twi_block_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG     = 6,
  parameter int FILT_LEN = 3,
  parameter logic [NREG*8-1:0] DEFAULTS = 48'hC3_96_0F_A5_7E_18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  import twi_pkg::*;

  localparam int BW   = $clog2(NREG + 3) + 1;
  localparam int SKIP = 2;

  logic scl_f, sda_f, scl_q, sda_q;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  twi_deglitch #(.STABLE(FILT_LEN)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
  twi_deglitch #(.STABLE(FILT_LEN)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;

  phase_t        phase;
  logic [3:0]    bitc;
  logic [7:0]    sh;
  logic          is_addr;
  logic          rw;
  logic [BW-1:0] bidx;

  logic          wr_en;
  logic [BW-1:0] wr_idx, rd_idx;
  logic [7:0]    rd_data, tx_byte;
  logic [BW-1:0] bidx_nx;

  assign bidx_nx = (bidx == '1) ? bidx : bidx + 1'b1;
  assign wr_idx  = bidx - BW'(SKIP);
  assign rd_idx  = bidx - 1'b1;
  assign tx_byte = (bidx == '0) ? 8'(NREG) : rd_data;
  assign wr_en   = (phase == PH_RX) && scl_fall && (bitc == 4'd8) && !is_addr
                   && (bidx >= BW'(SKIP)) && (bidx < BW'(NREG + SKIP));

  twi_regbank #(.NREG(NREG), .DW(8), .IW(BW), .DEFAULTS(DEFAULTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(sh),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitc    <= '0;
      sh      <= '0;
      is_addr <= 1'b0;
      rw      <= 1'b0;
      bidx    <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_RX;
      bitc    <= '0;
      is_addr <= 1'b1;
      bidx    <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      phase   <= PH_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bitc != 4'd8) begin
            sh   <= {sh[6:0], sda_f};
            bitc <= bitc + 1'b1;
          end else if (scl_fall && bitc == 4'd8) begin
            if (is_addr) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw      <= sh[0];
                is_addr <= 1'b0;
                sda_oe  <= 1'b1;
                phase   <= PH_RX_ACK;
              end else begin
                phase   <= PH_IGNORE;
              end
            end else begin
              bidx   <= bidx_nx;
              sda_oe <= 1'b1;
              phase  <= PH_RX_ACK;
            end
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bitc <= '0;
            if (rw) begin
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise && bitc != 4'd8) begin
            bitc <= bitc + 1'b1;
          end else if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b0;
              phase  <= PH_TX_ACK;
            end else begin
              sh     <= {sh[6:0], 1'b1};
              sda_oe <= ~sh[6];
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            if (sda_f) phase <= PH_IGNORE;
            else       bidx  <= bidx_nx;
          end else if (scl_fall) begin
            sh     <= tx_byte;
            sda_oe <= ~tx_byte[7];
            bitc   <= '0;
            phase  <= PH_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_block_regs_chk.sv
module twi_block_regs_chk #(
  parameter int NREG = 6,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              stop_evt,
  input twi_pkg::phase_t   phase,
  input logic [NREG*8-1:0] regs_o
);
  import twi_pkg::*;

  logic in_rst_d;
  always_ff @(posedge clk) in_rst_d <= !rst_n;

  // R1: bank holds defaults and SDA is released while reset is held
  always @(posedge clk)
    if (in_rst_d && !rst_n)
      a_r1_reset_defaults: assert (regs_o == DEFAULTS && !sda_oe);

  // R10: the data driver moves only while the filtered clock is low
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  // R5/R6: a register changes only together with the acknowledge of its byte
  a_r5_store_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> sda_oe);

  // R3: idle or ignoring means the line is never pulled
  a_r3_quiet_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_IGNORE) |-> !sda_oe);

  // R9: a STOP always leaves SDA released
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind twi_block_regs twi_block_regs_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .stop_evt(stop_evt), .phase(phase), .regs_o(regs_o));

// File: tb/twi_block_regs_test.sv
module twi_block_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;
  localparam logic [47:0] DEFS = 48'hC3_96_0F_A5_7E_18;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_h, sda_h;
  logic sda_oe;
  logic [47:0] regs_o;
  wire  sda_line = sda_h & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  int oe_bad = 0;
  bit cmp_on = 0;
  bit done   = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_block_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  function automatic logic [47:0] model_flat();
    logic [47:0] f;
    for (int i = 0; i < 6; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference bank compared on every clock between transactions (R5, R6, R7, R3, R4)
  always @(negedge clk) begin
    if (cmp_on && !done) check(regs_o == model_flat(), "R5/R6 bank vs model", regs_o, model_flat());
    if (rst_n && scl_h && sda_oe !== oe_prev) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    cmp_on = 0;
    sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask

  task automatic bus_restart();
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq(2);
    cmp_on = 1;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(); scl_h = 1'b1; wq(2); scl_h = 1'b0; wq();
    end
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq();
    acked = ~sda_line;
    wq(); scl_h = 1'b0; wq();
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_h = 1'b1; wq(); b[i] = sda_line; wq(); scl_h = 1'b0;
    end
    wq(); sda_h = nack; wq(); scl_h = 1'b1; wq(2); scl_h = 1'b0; wq();
    sda_h = 1'b1;
  endtask

  // full block write; updates the reference model for every acknowledged data byte
  task automatic blk_write(input logic [7:0] data [], input string req);
    bit a;
    bus_start();
    put_byte(8'hD2, a); check(a, "R2 write address ack", a, 1);
    put_byte(8'hAA, a); check(a, "R4 command byte ack", a, 1);
    put_byte(8'h55, a); check(a, "R4 length byte ack", a, 1);
    foreach (data[k]) begin
      put_byte(data[k], a);
      check(a, req, a, 1);
      if (k < 6) model[k] = data[k];
    end
    bus_stop();
  endtask

  initial begin
    logic [7:0] b;
    bit a;
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1;
    for (int i = 0; i < 6; i++) model[i] = DEFS[i*8 +: 8];
    repeat (5) @(negedge clk);
    check(regs_o == DEFS, "R1 defaults in reset", regs_o, DEFS);
    check(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_on = 1;
    check(regs_o == DEFS, "R1 defaults after reset", regs_o, DEFS);

    // full write of six registers (R4, R5)
    blk_write('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, "R5 data byte ack");
    check(regs_o == 48'h66_55_44_33_22_11, "R4 R5 full write", regs_o, 48'h66_55_44_33_22_11);

    // read back (R2, R8), extra byte reads 0xFF, then NACK (R9)
    bus_start();
    put_byte(8'hD3, a); check(a, "R2 read address ack", a, 1);
    get_byte(1'b0, b); check(b == 8'h06, "R8 length byte", b, 8'h06);
    for (int i = 0; i < 6; i++) begin
      get_byte(1'b0, b); check(b == model[i], "R8 register read", b, model[i]);
    end
    get_byte(1'b1, b); check(b == 8'hFF, "R8 past last register", b, 8'hFF);
    wq(); check(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    bus_stop();

    // early stop after two data bytes (R6)
    blk_write('{8'hA1, 8'hB2}, "R6 partial data ack");
    check(regs_o == 48'h66_55_44_33_B2_A1, "R6 partial write", regs_o, 48'h66_55_44_33_B2_A1);

    // eight data bytes: last two acknowledged but not stored (R7)
    blk_write('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08}, "R7 overflow byte ack");
    check(regs_o == 48'h06_05_04_03_02_01, "R7 overflow not stored", regs_o, 48'h06_05_04_03_02_01);

    // wrong address: silent, nothing stored (R3)
    bus_start();
    put_byte(8'hA4, a); check(!a, "R3 no ack for foreign address", a, 0);
    put_byte(8'h00, a); check(!a, "R3 no ack after mismatch", a, 0);
    put_byte(8'h00, a);
    put_byte(8'h9C, a); check(!a, "R3 data ignored", a, 0);
    bus_stop();
    check(regs_o == 48'h06_05_04_03_02_01, "R3 bank unchanged", regs_o, 48'h06_05_04_03_02_01);

    // repeated START switches to a read starting at register 0 (R10)
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    put_byte(8'hE7, a); check(a, "R10 data before restart ack", a, 1);
    model[0] = 8'hE7;
    bus_restart();
    put_byte(8'hD3, a); check(a, "R10 address after restart ack", a, 1);
    get_byte(1'b0, b); check(b == 8'h06, "R10 length after restart", b, 8'h06);
    get_byte(1'b0, b); check(b == 8'hE7, "R10 register 0 after restart", b, 8'hE7);
    get_byte(1'b1, b); check(b == 8'h02, "R10 register 1 after restart", b, 8'h02);
    bus_stop();

    // NACK on the first read byte: following clocks see a released line (R9)
    bus_start();
    put_byte(8'hD3, a);
    get_byte(1'b1, b); check(b == 8'h06, "R9 length before nack", b, 8'h06);
    get_byte(1'b1, b); check(b == 8'hFF, "R9 line released after nack", b, 8'hFF);
    bus_stop();

    check(oe_bad == 0, "R10 sda_oe steady while SCL high", oe_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule